// File: doc/BRIEF.md
# Dual-Format SPI Register Slave

This block is an SPI mode-0 slave that turns serial transactions from a host into single-cycle accesses on a byte-wide register bus. The host opens a transaction by pulling chip select low and sending a command. A command is either one byte, for a 6-bit short address space, or two bytes, for a 10-bit long address space. The first bit of the command picks the format. Data bytes follow the command. Each one is a read or a write at the current address, and the address steps forward after every byte, so a long run of bytes can fill or drain a FIFO-like region in one chip-select window.

The serial pins are oversampled in the system clock through a short synchronizer chain, and SCK edges are found by comparing successive samples. This is why the host clock must stay at 1 MHz or below, far under the system clock rate. On the register side, the block issues one-cycle write and read strobes. The register file must present read data on the cycle after a read strobe. Reads prefetch: the strobe for a byte goes out as soon as the previous byte completes, so its most significant bit is on MISO before the host's next sampling edge.

Top module: `dual_spi_regslave`

## Requirements
- R1: After reset and while chip select is high, MISO is 0 and neither reg_wr nor reg_rd is pulsed.
- R2: A short command byte has bit 7 = 0, address in bits 6:1 and bit 0 = 1 for write. The data byte that follows it produces one reg_wr pulse with reg_long = 0, reg_addr = that address and reg_wdata = the byte.
- R3: A short command with bit 0 = 0 is a read. During the next byte MISO carries the register value, most significant bit first, valid at each rising SCK edge.
- R4: A long command is two bytes, most significant first: bit 15 = 1, address in bits 14:5, bit 4 = 1 for write, bits 3:0 ignored. A following data byte is written with reg_long = 1 and that 10-bit address.
- R5: A long command with bit 4 = 0 is a read. The register value at the 10-bit address is returned on MISO during the data byte.
- R6: In a write burst, each further data byte is written to the next consecutive address.
- R7: In a read burst, each further data byte returns the value at the next consecutive address.
- R8: Burst addresses wrap modulo 64 for short commands and modulo 1024 for long commands. A short access never drives reg_addr bits 9:6 to anything but 0.
- R9: Raising chip select at any point ends the transaction. A partly shifted byte is not written, and the next transaction is decoded as a new command.
- R10: MISO is 0 during command bytes and during write data bytes.
- R11: reg_wr and reg_rd are single-cycle pulses and never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCK |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host, idle low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_miso | output | 1 | Serial data to the host |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_rd | output | 1 | One-cycle register read strobe |
| reg_long | output | 1 | 1 when the access is in the long address space |
| reg_addr | output | 10 | Register address; short accesses use bits 5:0 |
| reg_wdata | output | 8 | Write data, valid with reg_wr |
| reg_rdata | input | 8 | Read data, valid the cycle after reg_rd |

## Verification
Some rules are checked on every cycle by assertions. The strobes must stay one-cycle pulses and must never overlap. A short access must keep the upper address bits at zero. MISO must stay quiet while the block is idle or decoding a command. The directed scenarios show what only end-to-end traffic can show: that each command format decodes its address and direction bit correctly, ignored bits included. They also show that read data comes back bit-exact on MISO, that bursts step and wrap at 63 and 1023, and that raising chip select mid-byte or mid-command leaves the registers untouched and restarts decoding.

// File: rtl/spireg_pkg.sv
// Shared widths and the transaction phase type for the SPI register slave.
// Assumes: byte-wide data, a one-byte short command and a two-byte long command.
package spireg_pkg;
    localparam int DATA_W  = 8;
    localparam int SHORT_W = 6;
    localparam int LONG_W  = 10;

    typedef enum logic [1:0] {
        PH_CMD0 = 2'd0,
        PH_CMD1 = 2'd1,
        PH_DATA = 2'd2
    } phase_t;
endpackage

// File: rtl/spireg_sync.sv
// Oversamples the three serial inputs into the system clock and reports SCK
// edges as one-cycle pulses. Assumes SCK is far slower than clk, so every SCK
// level lasts many clk cycles. All three signals use the same chain depth,
// so MOSI stays aligned with the SCK edges that sample it.
module spireg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic mosi,
    input  logic cs_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic mosi_s,
    output logic cs_act
);
    localparam int NSIG = 3;
    localparam logic [NSIG-1:0] IDLE = 3'b100; // {cs_n, mosi, sck} at rest

    logic [NSIG-1:0] raw;
    logic [NSIG-1:0] synced;
    logic            sck_d;

    assign raw = {cs_n, mosi, sck};

    for (genvar gi = 0; gi < NSIG; gi++) begin : g_chain
        logic [STAGES-1:0] chain;
        // Shift one input through its synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{IDLE[gi]}};
            else        chain <= {chain[STAGES-2:0], raw[gi]};
        end
        assign synced[gi] = chain[STAGES-1];
    end

    // Keep the previous synchronized SCK level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= synced[0];
    end

    assign sck_rise = synced[0] & ~sck_d;
    assign sck_fall = ~synced[0] & sck_d;
    assign mosi_s   = synced[1];
    assign cs_act   = ~synced[2];
endmodule

// File: rtl/spireg_deser.sv
// Collects MOSI bits, most significant first, on rising SCK edges. When the
// eighth bit arrives, it raises byte_done for one cycle with the full byte.
// Clearing cs_act resets the bit count, so a partial byte is dropped.
module spireg_deser #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_act,
    input  logic          sck_rise,
    input  logic          mosi_s,
    output logic          byte_done,
    output logic [DW-1:0] rx_byte
);
    localparam int CW = $clog2(DW);

    logic [DW-1:0] shreg;
    logic [CW-1:0] bit_cnt;

    // Shift in bits and flag each completed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '0;
            bit_cnt   <= '0;
            byte_done <= 1'b0;
            rx_byte   <= '0;
        end else begin
            byte_done <= 1'b0;
            if (!cs_act) begin
                bit_cnt <= '0;
            end else if (sck_rise) begin
                shreg   <= {shreg[DW-2:0], mosi_s};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == CW'(DW-1)) begin
                    byte_done <= 1'b1;
                    rx_byte   <= {shreg[DW-2:0], mosi_s};
                    bit_cnt   <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/spireg_engine.sv
// Decodes the short and long command formats, holds the current address and
// direction, and drives the register bus strobes. A read strobe is issued two
// cycles after each byte boundary and load follows one cycle later, when the
// register file's data is valid. A write strobe goes out the cycle after a
// data byte completes, and the address steps forward the cycle after that.
module spireg_engine
    import spireg_pkg::*;
#(
    parameter int DW  = DATA_W,
    parameter int SAW = SHORT_W,
    parameter int LAW = LONG_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cs_act,
    input  logic           byte_done,
    input  logic [DW-1:0]  rx_byte,
    output logic           reg_wr,
    output logic           reg_rd,
    output logic           reg_long,
    output logic [LAW-1:0] reg_addr,
    output logic [DW-1:0]  reg_wdata,
    output logic           load,
    output logic           rd_phase,
    output logic           in_cmd
);
    localparam int LO_BITS = LAW - (DW - 1);    // address bits in second byte
    localparam int WR_POS  = DW - 1 - LO_BITS;  // direction bit in second byte

    phase_t         phase;
    logic [DW-1:0]  cmd_hi;
    logic [LAW-1:0] addr_q;
    logic [LAW-1:0] addr_inc;
    logic           is_long, is_wr;
    logic           rd_req, wr_q, rd_q, load_q;

    // Next burst address, wrapping within the active address space.
    always_comb begin
        if (is_long) addr_inc = addr_q + 1'b1;
        else         addr_inc = {{(LAW-SAW){1'b0}}, addr_q[SAW-1:0] + 1'b1};
    end

    // Phase sequencing, command decode and strobe generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_CMD0;
            cmd_hi    <= '0;
            addr_q    <= '0;
            is_long   <= 1'b0;
            is_wr     <= 1'b0;
            rd_req    <= 1'b0;
            wr_q      <= 1'b0;
            rd_q      <= 1'b0;
            load_q    <= 1'b0;
            reg_wdata <= '0;
        end else begin
            wr_q   <= 1'b0;
            rd_req <= 1'b0;
            rd_q   <= rd_req;
            load_q <= rd_q;
            if (wr_q) addr_q <= addr_inc;
            if (!cs_act) begin
                phase <= PH_CMD0;
            end else if (byte_done) begin
                case (phase)
                    PH_CMD0: begin
                        if (rx_byte[DW-1]) begin
                            cmd_hi <= rx_byte;
                            phase  <= PH_CMD1;
                        end else begin
                            addr_q  <= {{(LAW-SAW){1'b0}}, rx_byte[SAW:1]};
                            is_long <= 1'b0;
                            is_wr   <= rx_byte[0];
                            rd_req  <= ~rx_byte[0];
                            phase   <= PH_DATA;
                        end
                    end
                    PH_CMD1: begin
                        addr_q  <= {cmd_hi[DW-2:0], rx_byte[DW-1 -: LO_BITS]};
                        is_long <= 1'b1;
                        is_wr   <= rx_byte[WR_POS];
                        rd_req  <= ~rx_byte[WR_POS];
                        phase   <= PH_DATA;
                    end
                    default: begin
                        if (is_wr) begin
                            wr_q      <= 1'b1;
                            reg_wdata <= rx_byte;
                        end else begin
                            addr_q <= addr_inc;
                            rd_req <= 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    assign reg_wr   = wr_q;
    assign reg_rd   = rd_q;
    assign reg_long = is_long;
    assign reg_addr = addr_q;
    assign load     = load_q;
    assign rd_phase = (phase == PH_DATA) && !is_wr;
    assign in_cmd   = (phase != PH_DATA);
endmodule

// File: rtl/spireg_txshift.sv
// Holds a read byte and presents it on MISO, most significant bit first. A
// new bit goes out on each falling SCK edge, so the host samples it on the
// next rising edge. When en is low, MISO is held at 0.
module spireg_txshift #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          load,
    input  logic [DW-1:0] ld_data,
    input  logic          sck_fall,
    output logic          miso
);
    logic [DW-1:0] tx;
    logic          miso_q;

    // Load read data and shift it out on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx     <= '0;
            miso_q <= 1'b0;
        end else begin
            if (load)                 tx <= ld_data;
            else if (en && sck_fall)  tx <= {tx[DW-2:0], 1'b0};
            if (!en)                       miso_q <= 1'b0;
            else if (sck_fall && !load)    miso_q <= tx[DW-1];
        end
    end

    assign miso = miso_q;
endmodule

// File: rtl/dual_spi_regslave.sv
// Top level of the SPI mode-0 register slave. It chains the input
// synchronizer, the byte deserializer, the command engine and the MISO
// shifter. Assumes SCK at or below 1 MHz against a much faster clk, and a
// register file that answers reg_rd with reg_rdata on the following cycle.
module dual_spi_regslave
    import spireg_pkg::*;
#(
    parameter int DW          = DATA_W,
    parameter int SAW         = SHORT_W,
    parameter int LAW         = LONG_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           spi_sck,
    input  logic           spi_mosi,
    input  logic           spi_cs_n,
    output logic           spi_miso,
    output logic           reg_wr,
    output logic           reg_rd,
    output logic           reg_long,
    output logic [LAW-1:0] reg_addr,
    output logic [DW-1:0]  reg_wdata,
    input  logic [DW-1:0]  reg_rdata
);
    logic          sck_rise, sck_fall, mosi_s, cs_act;
    logic          byte_done;
    logic [DW-1:0] rx_byte;
    logic          load, rd_phase, in_cmd;
    logic          tx_en;

    spireg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (spi_sck),
        .mosi     (spi_mosi),
        .cs_n     (spi_cs_n),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .mosi_s   (mosi_s),
        .cs_act   (cs_act)
    );

    spireg_deser #(.DW(DW)) u_deser (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .sck_rise  (sck_rise),
        .mosi_s    (mosi_s),
        .byte_done (byte_done),
        .rx_byte   (rx_byte)
    );

    spireg_engine #(.DW(DW), .SAW(SAW), .LAW(LAW)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_long  (reg_long),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .load      (load),
        .rd_phase  (rd_phase),
        .in_cmd    (in_cmd)
    );

    assign tx_en = rd_phase & cs_act;

    spireg_txshift #(.DW(DW)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (tx_en),
        .load     (load),
        .ld_data  (reg_rdata),
        .sck_fall (sck_fall),
        .miso     (spi_miso)
    );
endmodule

// File: rtl/spireg_checker.sv
// Cycle-level rules for the SPI register slave, bound to the top module.
module spireg_checker #(
    parameter int SAW = 6,
    parameter int LAW = 10
) (
    input logic           clk,
    input logic           rst_n,
    input logic           reg_wr,
    input logic           reg_rd,
    input logic           reg_long,
    input logic [LAW-1:0] reg_addr,
    input logic           spi_miso,
    input logic           in_cmd,
    input logic           cs_act
);
    assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));

    assert_wr_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    assert_rd_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);

    assert_short_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_wr || reg_rd) && !reg_long) |-> (reg_addr[LAW-1:SAW] == '0));

    assert_cmd_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cmd && $past(in_cmd)) |-> !spi_miso);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_act && $past(!cs_act)) |-> !spi_miso);
endmodule

bind dual_spi_regslave spireg_checker #(.SAW(SAW), .LAW(LAW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_long (reg_long),
    .reg_addr (reg_addr),
    .spi_miso (spi_miso),
    .in_cmd   (in_cmd),
    .cs_act   (cs_act)
);

// File: tb/tb_dual_spi_regslave.sv
// Directed bench: a host-side SPI driver at 1 MHz and a register file model.
module tb_dual_spi_regslave;
    localparam int HALF_CYC = 100;      // clk cycles per SCK half period (1 MHz)

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sck = 1'b0, spi_mosi = 1'b0, spi_cs_n = 1'b1;
    logic       spi_miso;
    logic       reg_wr, reg_rd, reg_long;
    logic [9:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;

    int total = 0, bad = 0;
    int strobes = 0;
    int wr_n = 0;
    int lg_addr [0:31];
    int lg_data [0:31];
    int lg_long [0:31];
    logic [7:0] smem [0:63];
    logic [7:0] lmem [0:1023];

    always #2.5 clk = ~clk;

    dual_spi_regslave dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_cs_n(spi_cs_n), .spi_miso(spi_miso), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_long(reg_long), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    // Register file model with one-cycle read latency and a write log.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) smem[i] <= 8'(i * 7 + 3);
            for (int i = 0; i < 1024; i++) lmem[i] <= 8'(i * 13) ^ 8'h5A;
            reg_rdata <= 8'h00;
        end else begin
            if (reg_wr || reg_rd) strobes <= strobes + 1;
            if (reg_wr) begin
                if (reg_long) lmem[reg_addr] <= reg_wdata;
                else          smem[reg_addr[5:0]] <= reg_wdata;
                if (wr_n < 32) begin
                    lg_addr[wr_n] <= int'(reg_addr);
                    lg_data[wr_n] <= int'(reg_wdata);
                    lg_long[wr_n] <= int'(reg_long);
                end
                wr_n <= wr_n + 1;
            end
            if (reg_rd) reg_rdata <= reg_long ? lmem[reg_addr] : smem[reg_addr[5:0]];
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            spi_mosi = tx[i];
            wait_cyc(HALF_CYC);
            spi_sck = 1'b1;
            rx[i] = spi_miso;
            wait_cyc(HALF_CYC);
            spi_sck = 1'b0;
        end
    endtask

    task automatic spi_bits(input logic [7:0] tx, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            spi_mosi = tx[i];
            wait_cyc(HALF_CYC);
            spi_sck = 1'b1;
            wait_cyc(HALF_CYC);
            spi_sck = 1'b0;
        end
    endtask

    task automatic cs_on;
        spi_cs_n = 1'b0;
        wait_cyc(HALF_CYC);
    endtask

    task automatic cs_off;
        wait_cyc(HALF_CYC);
        spi_cs_n = 1'b1;
        spi_mosi = 1'b0;
        wait_cyc(40);
    endtask

    function automatic logic [15:0] long_cmd(input int addr, input bit wr, input int nib);
        return 16'h8000 | 16'((addr & 10'h3FF) << 5) | (wr ? 16'h0010 : 16'h0) | 16'(nib & 4'hF);
    endfunction

    task automatic t_reset;
        wait_cyc(20);
        chk("R1 miso idle", int'(spi_miso), 0);
        chk("R1 no strobes", strobes, 0);
    endtask

    task automatic t_short_write;
        logic [7:0] rx;
        int base = wr_n;
        cs_on();
        spi_byte({1'b0, 6'h15, 1'b1}, rx);
        spi_byte(8'hA7, rx);
        chk("R10 miso during write data", int'(rx), 0);
        cs_off();
        chk("R2 write count", wr_n - base, 1);
        chk("R2 write addr", lg_addr[base], 'h15);
        chk("R2 write space", lg_long[base], 0);
        chk("R2 write data", lg_data[base], 'hA7);
    endtask

    task automatic t_short_read;
        logic [7:0] rx;
        int exp = int'(smem[6'h0A]);
        cs_on();
        spi_byte({1'b0, 6'h0A, 1'b0}, rx);
        chk("R10 miso during short cmd", int'(rx), 0);
        spi_byte(8'h00, rx);
        chk("R3 short read data", int'(rx), exp);
        cs_off();
    endtask

    task automatic t_long_write;
        logic [7:0] rx;
        logic [15:0] c = long_cmd('h2C5, 1'b1, 'hF);
        int base = wr_n;
        cs_on();
        spi_byte(c[15:8], rx);
        spi_byte(c[7:0], rx);
        spi_byte(8'h3C, rx);
        cs_off();
        chk("R4 long write count", wr_n - base, 1);
        chk("R4 long write addr", lg_addr[base], 'h2C5);
        chk("R4 long write space", lg_long[base], 1);
        chk("R4 long write data", int'(lmem['h2C5]), 'h3C);
    endtask

    task automatic t_long_read;
        logic [7:0] rx0, rx1, rx;
        logic [15:0] c = long_cmd('h133, 1'b0, 'h5);
        int exp = int'(lmem['h133]);
        cs_on();
        spi_byte(c[15:8], rx0);
        spi_byte(c[7:0], rx1);
        spi_byte(8'hFF, rx);
        cs_off();
        chk("R10 miso during long cmd", int'({rx0, rx1}), 0);
        chk("R5 long read data", int'(rx), exp);
    endtask

    task automatic t_write_burst;
        logic [7:0] rx;
        int base = wr_n;
        int exp_a [4] = '{'h3E, 'h3F, 'h00, 'h01};
        cs_on();
        spi_byte({1'b0, 6'h3E, 1'b1}, rx);
        for (int k = 0; k < 4; k++) spi_byte(8'(8'h10 + k), rx);
        cs_off();
        chk("R6 burst write count", wr_n - base, 4);
        for (int k = 0; k < 4; k++) begin
            chk("R6 R8 burst write addr", lg_addr[base + k], exp_a[k]);
            chk("R6 burst write data", lg_data[base + k], 'h10 + k);
        end
    endtask

    task automatic t_read_burst;
        logic [7:0] rx;
        logic [15:0] c = long_cmd('h3FE, 1'b0, 'h0);
        int exp_a [4] = '{'h3FE, 'h3FF, 'h000, 'h001};
        int exp_d [4];
        for (int k = 0; k < 4; k++) exp_d[k] = int'(lmem[exp_a[k]]);
        cs_on();
        spi_byte(c[15:8], rx);
        spi_byte(c[7:0], rx);
        for (int k = 0; k < 4; k++) begin
            spi_byte(8'h00, rx);
            chk("R7 R8 burst read data", int'(rx), exp_d[k]);
        end
        cs_off();
        chk("R1 miso idle after read", int'(spi_miso), 0);
    endtask

    task automatic t_abort;
        logic [7:0] rx;
        logic [15:0] c = long_cmd('h0F0, 1'b1, 'h0);
        int base = wr_n;
        int exp5 = int'(smem[5]);
        cs_on();
        spi_byte({1'b0, 6'h05, 1'b1}, rx);
        spi_bits(8'hC3, 4);
        cs_off();
        chk("R9 partial byte not written", wr_n - base, 0);
        cs_on();
        spi_byte({1'b0, 6'h05, 1'b0}, rx);
        spi_byte(8'h00, rx);
        cs_off();
        chk("R9 register unchanged", int'(rx), exp5);
        cs_on();
        spi_byte(c[15:8], rx);
        cs_off();
        cs_on();
        spi_byte({1'b0, 6'h07, 1'b1}, rx);
        spi_byte(8'h99, rx);
        cs_off();
        chk("R9 fresh decode count", wr_n - base, 1);
        chk("R9 fresh decode addr", lg_addr[base], 'h07);
        chk("R9 fresh decode space", lg_long[base], 0);
        chk("R9 fresh decode data", lg_data[base], 'h99);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait_cyc(10);
        rst_n = 1'b1;
        t_reset();
        t_short_write();
        t_short_read();
        t_long_write();
        t_long_read();
        t_write_burst();
        t_read_burst();
        t_abort();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule